// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block decides when a processor subsystem may leave run mode for one of four low-power states, and when it must come back. Software requests a state by writing a one-hot code to a mode register. The write takes effect only if exactly one request bit is set and no enabled interrupt is pending. The two stop-class states also need a prior unlock: two back-to-back writes of fixed key bytes to a separate key register. The resulting state drives the clock-gating logic directly.

While in any low-power state, the block watches the interrupt enable and request vectors. The first enabled request returns it to run mode, clears the request readback and emits a one-cycle wake pulse. A vector-request flag is raised alongside the wake pulse only when the master interrupt enable is set. Otherwise the wake merely resumes execution at the next instruction.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: After reset, and while reset is held, `gate_mode` is 0 (run), `mode_rd` is 0 and `wake_pulse` and `vec_req` are 0.
- R2: In run mode, a mode-register write (`wr_addr`=0) whose data bits [3:0] equal 4'b0001 (halt) or 4'b0100 (fast halt) enters `gate_mode` 1 or 3 respectively on the next clock edge. `mode_rd` then shows the written bit. In run mode `mode_rd` is always 0.
- R3: A mode-register write with zero, two or more bits set in [3:0] is ignored: the block stays in run mode and `mode_rd` stays 0.
- R4: A mode-register write is ignored while any line has both `irq_en` and `irq_req` at 1 in the write cycle. A request on a line whose enable is 0 does not block entry.
- R5: Bit 1 (stop, `gate_mode` 2) and bit 3 (deep stop, `gate_mode` 4) are accepted only while the key sequence is armed. Without the arm, the write is ignored.
- R6: Key-register writes (`wr_addr`=1) of 8'h5A and then 8'hA5, with no other key write between them, arm the stop-class states. Any other key value resets the sequence.
- R7: A key-register write made while an enabled interrupt is pending is ignored and leaves the sequence position unchanged.
- R8: Entry into stop or deep stop consumes the arm, so the next stop-class request is ignored. Entry into halt or fast halt leaves the arm intact.
- R9: In a low-power state, an enabled pending interrupt returns `gate_mode` to 0 and `mode_rd` to 0 on the next edge. `wake_pulse` is high for exactly that one cycle, even if the request stays high.
- R10: `vec_req` is high together with `wake_pulse` exactly when `mie` was 1 in the cycle the wake was taken, and is otherwise 0.
- R11: While in a low-power state with no enabled interrupt pending, writes to either register have no effect and the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = mode register, 1 = key register |
| wr_data | input | 8 | Write data |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| irq_req | input | NUM_IRQ | Per-line interrupt requests |
| mie | input | 1 | Master interrupt enable |
| gate_mode | output | 3 | 0 run, 1 halt, 2 stop, 3 fast halt, 4 deep stop |
| mode_rd | output | 4 | Readback of the active request bit |
| wake_pulse | output | 1 | One-cycle wake indication |
| vec_req | output | 1 | Wake should vector to an interrupt |

## Verification
Two checks can land in the same cycle: the acceptance of an entry or key write, and the pending-interrupt block. The bench provokes this by driving a valid halt write together with an enabled request, and an 8'hA5 key write together with an enabled request. It judges the mode write by `gate_mode` staying 0 one edge later. It judges the key write by whether a later stop request, after a clean 8'hA5, is accepted, which shows that the sequence position survived. A request on a disabled line in the same cycle as a halt write confirms that only enabled lines block entry.

// File: rtl/lpm_entry_pkg.sv
package lpm_entry_pkg;
   localparam int unsigned REQ_W     = 4;
   localparam int unsigned BIT_HALT  = 0;
   localparam int unsigned BIT_STOP  = 1;
   localparam int unsigned BIT_HHALT = 2;
   localparam int unsigned BIT_DSTOP = 3;

   typedef enum logic [2:0] {
      LPM_RUN   = 3'd0,
      LPM_HALT  = 3'd1,
      LPM_STOP  = 3'd2,
      LPM_HHALT = 3'd3,
      LPM_DSTOP = 3'd4
   } lpm_mode_e;

   typedef enum logic [1:0] {
      KEY_IDLE  = 2'd0,
      KEY_HALF  = 2'd1,
      KEY_ARMED = 2'd2
   } key_stage_e;

   function automatic lpm_mode_e req_decode(input logic [REQ_W-1:0] r);
      if (r[BIT_DSTOP])      return LPM_DSTOP;
      else if (r[BIT_HHALT]) return LPM_HHALT;
      else if (r[BIT_STOP])  return LPM_STOP;
      else if (r[BIT_HALT])  return LPM_HALT;
      else                   return LPM_RUN;
   endfunction

   function automatic logic is_stop_kind(input logic [REQ_W-1:0] r);
      return r[BIT_STOP] | r[BIT_DSTOP];
   endfunction
endpackage

// File: rtl/lpm_pend_detect.sv
module lpm_pend_detect #(
   parameter int unsigned NUM_IRQ = 16
) (
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic [NUM_IRQ-1:0] irq_req,
   output logic               pending
);
   logic [NUM_IRQ-1:0] hit;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      assign hit[i] = irq_en[i] & irq_req[i];
   end

   assign pending = |hit;
endmodule

// File: rtl/lpm_unlock_seq.sv
module lpm_unlock_seq #(
   parameter int unsigned     KEY_W      = 8,
   parameter logic [KEY_W-1:0] KEY_FIRST  = 8'h5A,
   parameter logic [KEY_W-1:0] KEY_SECOND = 8'hA5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_key,
   input  logic [KEY_W-1:0] key_data,
   input  logic             pending,
   input  logic             consume,
   output logic             armed
);
   import lpm_entry_pkg::*;

   key_stage_e stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= KEY_IDLE;
      end else if (consume) begin
         stage_q <= KEY_IDLE;
      end else if (wr_key && !pending) begin
         if (stage_q == KEY_HALF && key_data == KEY_SECOND) stage_q <= KEY_ARMED;
         else if (key_data == KEY_FIRST)                    stage_q <= KEY_HALF;
         else                                                stage_q <= KEY_IDLE;
      end
   end

   assign armed = (stage_q == KEY_ARMED);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
   import lpm_entry_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_mode,
   input  logic [REQ_W-1:0] wr_bits,
   input  logic             pending,
   input  logic             armed,
   input  logic             mie,
   output lpm_mode_e        mode_q,
   output logic [REQ_W-1:0] req_q,
   output logic             wake_q,
   output logic             vec_q,
   output logic             stop_take
);
   logic in_run, single, stop_kind, accept;

   always_comb begin
      in_run    = (mode_q == LPM_RUN);
      single    = $onehot(wr_bits);
      stop_kind = is_stop_kind(wr_bits);
      accept    = wr_mode & in_run & single & ~pending & (~stop_kind | armed);
      stop_take = accept & stop_kind;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= LPM_RUN;
         req_q  <= '0;
         wake_q <= 1'b0;
         vec_q  <= 1'b0;
      end else begin
         wake_q <= 1'b0;
         vec_q  <= 1'b0;
         if (in_run) begin
            if (accept) begin
               mode_q <= req_decode(wr_bits);
               req_q  <= wr_bits;
            end
         end else if (pending) begin
            mode_q <= LPM_RUN;
            req_q  <= '0;
            wake_q <= 1'b1;
            vec_q  <= mie;
         end
      end
   end
endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl #(
   parameter int unsigned      NUM_IRQ    = 16,
   parameter int unsigned      DATA_W     = 8,
   parameter int unsigned      KEY_W      = 8,
   parameter logic [KEY_W-1:0] KEY_FIRST  = 8'h5A,
   parameter logic [KEY_W-1:0] KEY_SECOND = 8'hA5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic               mie,
   output logic [2:0]         gate_mode,
   output logic [3:0]         mode_rd,
   output logic               wake_pulse,
   output logic               vec_req
);
   import lpm_entry_pkg::*;

   localparam logic ADDR_MODE = 1'b0;
   localparam logic ADDR_KEY  = 1'b1;

   if (NUM_IRQ < 1) begin : g_bad_irq
      $error("lpm_entry_ctrl: NUM_IRQ must be at least 1");
   end
   if (DATA_W < KEY_W || DATA_W < REQ_W) begin : g_bad_width
      $error("lpm_entry_ctrl: DATA_W too narrow for key or request field");
   end
   if (KEY_FIRST == KEY_SECOND) begin : g_bad_key
      $error("lpm_entry_ctrl: the two key bytes must differ");
   end

   logic       pending, armed, stop_take, in_run;
   logic       wr_mode, wr_key;
   lpm_mode_e  mode_q;
   logic [REQ_W-1:0] req_q;
   logic [DATA_W-1:0] data_unused;

   assign in_run  = (mode_q == LPM_RUN);
   assign wr_mode = wr_en & in_run & (wr_addr == ADDR_MODE);
   assign wr_key  = wr_en & in_run & (wr_addr == ADDR_KEY);
   assign data_unused = wr_data;

   lpm_pend_detect #(.NUM_IRQ(NUM_IRQ)) u_pend (
      .irq_en  (irq_en),
      .irq_req (irq_req),
      .pending (pending)
   );

   lpm_unlock_seq #(
      .KEY_W      (KEY_W),
      .KEY_FIRST  (KEY_FIRST),
      .KEY_SECOND (KEY_SECOND)
   ) u_unlock (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_key   (wr_key),
      .key_data (data_unused[KEY_W-1:0]),
      .pending  (pending),
      .consume  (stop_take),
      .armed    (armed)
   );

   lpm_mode_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_mode   (wr_mode),
      .wr_bits   (data_unused[REQ_W-1:0]),
      .pending   (pending),
      .armed     (armed),
      .mie       (mie),
      .mode_q    (mode_q),
      .req_q     (req_q),
      .wake_q    (wake_pulse),
      .vec_q     (vec_req),
      .stop_take (stop_take)
   );

   assign gate_mode = mode_q;
   assign mode_rd   = req_q;
endmodule

// File: rtl/lpm_entry_ctrl_chk.sv
module lpm_entry_ctrl_chk #(
   parameter int unsigned NUM_IRQ = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_IRQ-1:0] irq_en,
   input logic [NUM_IRQ-1:0] irq_req,
   input logic               mie,
   input logic [2:0]         gate_mode,
   input logic [3:0]         mode_rd,
   input logic               wake_pulse,
   input logic               vec_req
);
   logic pend_seen;
   assign pend_seen = |(irq_en & irq_req);

   AST_RUN_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_mode == 3'd0) |-> (mode_rd == 4'd0));                          // R2
   AST_READ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mode_rd));                                                   // R3
   AST_NO_ENTRY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_mode == 3'd0 && pend_seen) |=> (gate_mode == 3'd0));           // R4
   AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);                                          // R9
   AST_WAKE_FROM_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (gate_mode == 3'd0 && $past(gate_mode) != 3'd0));      // R9
   AST_VEC_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |-> wake_pulse);                                              // R10
   AST_VEC_FOLLOWS_MIE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (vec_req == $past(mie)));                              // R10
   AST_STANDBY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_mode != 3'd0 && !pend_seen) |=> $stable(gate_mode));            // R11
endmodule

bind lpm_entry_ctrl lpm_entry_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_en     (irq_en),
   .irq_req    (irq_req),
   .mie        (mie),
   .gate_mode  (gate_mode),
   .mode_rd    (mode_rd),
   .wake_pulse (wake_pulse),
   .vec_req    (vec_req)
);

// File: tb/lpm_entry_ctrl_bench.sv
module lpm_entry_ctrl_bench;
   localparam int NIRQ = 4;
   localparam int NV   = 27;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic            wr_addr = 1'b0;
   logic [7:0]      wr_data = '0;
   logic [NIRQ-1:0] irq_en = 4'b0001;
   logic [NIRQ-1:0] irq_req = '0;
   logic            mie = 1'b0;
   logic [2:0]      gate_mode;
   logic [3:0]      mode_rd;
   logic            wake_pulse, vec_req;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   lpm_entry_ctrl #(.NUM_IRQ(NIRQ)) u_lpm_entry_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .irq_en(irq_en), .irq_req(irq_req), .mie(mie),
      .gate_mode(gate_mode), .mode_rd(mode_rd),
      .wake_pulse(wake_pulse), .vec_req(vec_req)
   );

   // op: 0 mode write, 1 key write, 2 no write
   // fields: op, data, irq line 0, mie, exp mode, exp readback, exp wake, exp vec, req tag
   localparam logic [24:0] VEC [0:NV-1] = '{
      {2'd0, 8'h03, 1'b0, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd3},  // R3 two bits
      {2'd0, 8'h00, 1'b0, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd3},  // R3 zero bits
      {2'd0, 8'h01, 1'b1, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd4},  // R4 halt vs pending
      {2'd0, 8'h01, 1'b0, 1'b0, 3'd1, 4'h1, 1'b0, 1'b0, 4'd2},  // R2 halt
      {2'd0, 8'h04, 1'b0, 1'b0, 3'd1, 4'h1, 1'b0, 1'b0, 4'd11}, // R11 write in standby
      {2'd2, 8'h00, 1'b1, 1'b0, 3'd0, 4'h0, 1'b1, 1'b0, 4'd10}, // R10 wake, mie 0
      {2'd2, 8'h00, 1'b0, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd9},  // R9 pulse ends
      {2'd0, 8'h04, 1'b0, 1'b0, 3'd3, 4'h4, 1'b0, 1'b0, 4'd2},  // R2 fast halt
      {2'd2, 8'h00, 1'b1, 1'b1, 3'd0, 4'h0, 1'b1, 1'b1, 4'd10}, // R10 wake, mie 1
      {2'd0, 8'h02, 1'b0, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd5},  // R5 stop not armed
      {2'd1, 8'h5A, 1'b0, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd6},  // R6 first key
      {2'd1, 8'hA5, 1'b1, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd7},  // R7 key vs pending
      {2'd1, 8'hA5, 1'b0, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd7},  // R7 position kept
      {2'd0, 8'h02, 1'b0, 1'b0, 3'd2, 4'h2, 1'b0, 1'b0, 4'd5},  // R5 stop accepted
      {2'd2, 8'h00, 1'b1, 1'b1, 3'd0, 4'h0, 1'b1, 1'b1, 4'd9},  // R9 wake from stop
      {2'd0, 8'h08, 1'b0, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd8},  // R8 arm consumed
      {2'd1, 8'h5A, 1'b0, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd6},
      {2'd1, 8'h00, 1'b0, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd6},  // R6 wrong key resets
      {2'd1, 8'hA5, 1'b0, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd6},
      {2'd0, 8'h08, 1'b0, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd6},  // R6 not armed
      {2'd1, 8'h5A, 1'b0, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd6},
      {2'd1, 8'hA5, 1'b0, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd6},
      {2'd0, 8'h01, 1'b0, 1'b0, 3'd1, 4'h1, 1'b0, 1'b0, 4'd8},  // R8 halt keeps arm
      {2'd2, 8'h00, 1'b1, 1'b0, 3'd0, 4'h0, 1'b1, 1'b0, 4'd9},
      {2'd0, 8'h08, 1'b0, 1'b0, 3'd4, 4'h8, 1'b0, 1'b0, 4'd8},  // R8 deep stop
      {2'd2, 8'h00, 1'b1, 1'b1, 3'd0, 4'h0, 1'b1, 1'b1, 4'd9},
      {2'd0, 8'h0A, 1'b0, 1'b0, 3'd0, 4'h0, 1'b0, 1'b0, 4'd3}   // R3 two bits
   };

   task automatic check(input int rq, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, got, exp);
      end
   endtask

   task automatic check_all(input int rq, input int em, input int er, input int ew, input int ev);
      check(rq, "gate_mode", int'(gate_mode), em);
      check(rq, "mode_rd", int'(mode_rd), er);
      check(rq, "wake_pulse", int'(wake_pulse), ew);
      check(rq, "vec_req", int'(vec_req), ev);
   endtask

   task automatic drive(input int op, input logic [7:0] d, input logic irq0, input logic m);
      wr_en      = (op != 2);
      wr_addr    = (op == 1);
      wr_data    = d;
      irq_req[0] = irq0;
      mie        = m;
   endtask

   task automatic idle();
      wr_en = 1'b0; wr_data = '0; irq_req = '0; mie = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_all(1, 0, 0, 0, 0);                // R1 held in reset
      rst_n = 1'b1;
      @(negedge clk);
      check_all(1, 0, 0, 0, 0);                // R1 after release

      for (int i = 0; i < NV; i++) begin
         drive(int'(VEC[i][24:23]), VEC[i][22:15], VEC[i][14], VEC[i][13]);
         @(negedge clk);
         check_all(int'(VEC[i][3:0]), int'(VEC[i][12:10]), int'(VEC[i][9:6]),
                   int'(VEC[i][5]), int'(VEC[i][4]));
      end
      idle();
      @(negedge clk);

      // R4: request on a disabled line does not block entry
      irq_req[1] = 1'b1;
      drive(0, 8'h04, 1'b0, 1'b0);
      @(negedge clk);
      check(4, "gate_mode disabled line", int'(gate_mode), 3);
      idle();
      // R9: request held for three cycles gives one wake pulse
      irq_req[0] = 1'b1; mie = 1'b1;
      @(negedge clk);
      check(9, "wake first", int'(wake_pulse), 1);
      check(10, "vec first", int'(vec_req), 1);
      @(negedge clk);
      check(9, "wake second", int'(wake_pulse), 0);
      check(9, "mode after wake", int'(gate_mode), 0);
      @(negedge clk);
      check(9, "wake third", int'(wake_pulse), 0);
      idle();
      @(negedge clk);

      // R11: key writes during standby are ignored
      drive(0, 8'h01, 1'b0, 1'b0);
      @(negedge clk);
      drive(1, 8'h5A, 1'b0, 1'b0);
      @(negedge clk);
      drive(1, 8'hA5, 1'b0, 1'b0);
      @(negedge clk);
      check(11, "halt held", int'(gate_mode), 1);
      drive(2, 8'h00, 1'b1, 1'b0);
      @(negedge clk);
      drive(0, 8'h02, 1'b0, 1'b0);
      @(negedge clk);
      check(11, "stop refused, no arm from standby", int'(gate_mode), 0);

      // R1: reset in the middle of a low-power state
      drive(0, 8'h04, 1'b0, 1'b0);
      @(negedge clk);
      idle();
      rst_n = 1'b0;
      @(negedge clk);
      check_all(1, 0, 0, 0, 0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule